// File: doc/BRIEF.md
# Folded Three-Level Wavelet Decomposition Filter Bank

This block breaks a stream of signed samples into a three-level dyadic wavelet decomposition. It uses a four-tap Daubechies lowpass and highpass pair. A first stage filters every incoming sample and keeps one output in two. It produces the level-1 detail stream and a level-1 approximation stream. That approximation feeds a second, folded stage. In the folded stage, level 2 and level 3 share a single lowpass/highpass filter pair. Each level keeps its own delay line and takes a turn on the shared arithmetic when one of its pairs is complete.

A sample is accepted on any clock edge where the valid strobe is high. Level-1 details leave on a dedicated output. Level-2 and level-3 details share a second output, and each carries a level tag. The deepest approximation leaves on a third output. All arithmetic uses 12-bit signed words with 11 fractional coefficient bits. Every result is rounded and saturated back to 12 bits.

Top module: `wavelet3_fold_bank`

## Requirements
- R1: After reset, all three output valid flags are low and every delay line holds zero. The first results are therefore computed as if the earlier samples had been zero.
- R2: Every second accepted sample (the 2nd, 4th, ... since reset) completes a level-1 pair.
  - The level-1 detail is the highpass weights (-265, -459, 1713, -989) applied to that sample and its three predecessors, newest first.
  - The lowpass weights (989, 1713, 459, -265), in the same order, form the level-1 approximation that feeds level 2.
  - All weights are in units of 2^-11.
- R3: Each weighted sum is rounded by adding 1024 and then shifting right arithmetically by 11 bits.
- R4: Every rounded result is saturated to the range -2048 to 2047.
- R5: A clock edge with the input strobe low changes no state. The sample value presented on that edge has no effect on any later output.
- R6: Level 2 filters the level-1 approximation stream, and level 3 filters the level-2 approximation stream. Both use the pairing rule of R2.
  - Their details appear on the folded output, with fd_level equal to 2 or 3.
  - apx_valid is high only together with a level-3 detail, and apx_data then carries the level-3 lowpass result.
- R7: A level-1 detail appears in the cycle after the edge that accepted the sample completing its pair. A level-2 result appears two cycles after the level-1 output that completed its pair.
- R8: The shared filter pair produces at most one folded result per cycle. A level's pending pair is always consumed before that level completes another pair. When both levels wait, the lower level is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample strobe |
| in_x | input | 12 | Signed input sample |
| l1_valid | output | 1 | Level-1 detail valid |
| l1_detail | output | 12 | Signed level-1 detail coefficient |
| fd_valid | output | 1 | Folded-stage detail valid |
| fd_level | output | 2 | Level tag of the folded detail (2 or 3) |
| fd_detail | output | 12 | Signed level-2 or level-3 detail coefficient |
| apx_valid | output | 1 | Deepest approximation valid |
| apx_data | output | 12 | Signed level-3 approximation coefficient |

## Verification
- Pair alignment after reset (R1, R2): the bench starts with an impulse and a ramp. A design that got the alignment wrong would emit coefficients one sample out of phase or mix in stale history.
- Dropped strobes (R5): long stretches of dropped strobes carry extreme garbage values. A design that shifted on an idle cycle would corrupt every later level.
- Saturation (R4): constant full-scale inputs push the cascaded lowpass past full scale, and alternating full-scale inputs do the same to the highpass. A design without saturation would wrap to the opposite sign.
- Interleaving (R6, R8): random input with random gaps exercises the folded schedule. A scheduler that lost a job, swapped the level tags or reordered results would leave queue entries unmatched or deliver wrong values.

// File: rtl/wvl_pkg.sv
package wvl_pkg;

   // Number of filter taps and fractional bits of the fixed-point weights
   localparam int TAPS      = 4;
   localparam int COEF_FRAC = 11;
   localparam int COEF_W    = 13;

   typedef logic signed [COEF_W-1:0] coef_t;

   // Four-tap Daubechies lowpass weights scaled by 2^COEF_FRAC, newest sample first
   localparam coef_t LO_TAP [TAPS] = '{13'sd989, 13'sd1713, 13'sd459, -13'sd265};

   // Quadrature mirror: reversed lowpass taps with alternating sign
   function automatic coef_t hi_tap(input int idx);
      coef_t v;
      v = LO_TAP[TAPS-1-idx];
      return (idx % 2 == 0) ? v : -v;
   endfunction

endpackage

// File: rtl/wvl_dot4.sv
module wvl_dot4 #(
   parameter int W    = 12,
   parameter int FRAC = 11,
   parameter bit HIGH = 1'b0
) (
   input  logic signed [W-1:0] win [wvl_pkg::TAPS],
   output logic signed [W-1:0] y
);

   localparam int NT  = wvl_pkg::TAPS;
   localparam int PW  = W + wvl_pkg::COEF_W;
   localparam int SW  = PW + $clog2(NT);
   localparam logic signed [SW-1:0] HALF   = SW'(2**(FRAC-1));
   localparam logic signed [SW-1:0] HI_LIM = SW'((2**(W-1)) - 1);
   localparam logic signed [SW-1:0] LO_LIM = ~HI_LIM;

   if (FRAC != wvl_pkg::COEF_FRAC) begin : g_bad_frac
      $error("wvl_dot4: FRAC must match the coefficient scaling");
   end
   if (W < 4) begin : g_bad_w
      $error("wvl_dot4: sample width too small");
   end

   wvl_pkg::coef_t      c    [NT];
   logic signed [PW-1:0] prod [NT];
   logic signed [SW-1:0] acc;
   logic signed [SW-1:0] rnd;
   logic signed [SW-1:0] shf;

   for (genvar i = 0; i < NT; i++) begin : g_tap
      if (HIGH) begin : g_hi
         assign c[i] = wvl_pkg::hi_tap(i);
      end else begin : g_lo
         assign c[i] = wvl_pkg::LO_TAP[i];
      end
      assign prod[i] = win[i] * c[i];
   end

   always_comb begin
      acc = '0;
      for (int i = 0; i < NT; i++) begin
         acc = acc + SW'(prod[i]);
      end
      rnd = acc + HALF;
      shf = rnd >>> FRAC;
      if (shf > HI_LIM) begin
         y = HI_LIM[W-1:0];
      end else if (shf < LO_LIM) begin
         y = LO_LIM[W-1:0];
      end else begin
         y = shf[W-1:0];
      end
   end

endmodule

// File: rtl/wvl_stage1.sv
module wvl_stage1 #(
   parameter int W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_x,
   output logic                out_valid,
   output logic signed [W-1:0] out_lo,
   output logic signed [W-1:0] out_hi
);

   localparam int NT = wvl_pkg::TAPS;
   localparam int HD = NT - 1;

   logic signed [W-1:0] hist [HD];
   logic signed [W-1:0] win  [NT];
   logic                odd;
   logic signed [W-1:0] lo_y;
   logic signed [W-1:0] hi_y;

   assign win[0] = in_x;
   for (genvar i = 1; i < NT; i++) begin : g_win
      assign win[i] = hist[i-1];
   end

   wvl_dot4 #(.W(W), .FRAC(wvl_pkg::COEF_FRAC), .HIGH(1'b0)) u_lo (.win(win), .y(lo_y));
   wvl_dot4 #(.W(W), .FRAC(wvl_pkg::COEF_FRAC), .HIGH(1'b1)) u_hi (.win(win), .y(hi_y));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < HD; i++) hist[i] <= '0;
         odd       <= 1'b0;
         out_valid <= 1'b0;
         out_lo    <= '0;
         out_hi    <= '0;
      end else begin
         out_valid <= in_valid && odd;
         if (in_valid) begin
            hist[0] <= in_x;
            for (int i = 1; i < HD; i++) hist[i] <= hist[i-1];
            odd <= ~odd;
            if (odd) begin
               out_lo <= lo_y;
               out_hi <= hi_y;
            end
         end
      end
   end

   // R5: an idle edge keeps the pair phase and emits nothing
   p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(odd) && !out_valid));

   // R2: decimation by two, never two outputs on back-to-back cycles
   p_pair_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

endmodule

// File: rtl/wvl_fold.sv
module wvl_fold #(
   parameter int W  = 12,
   parameter int NF = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push_valid,
   input  logic signed [W-1:0]           push_x,
   output logic                          res_valid,
   output logic [((NF>1)?$clog2(NF):1)-1:0] res_lane,
   output logic signed [W-1:0]           res_lo,
   output logic signed [W-1:0]           res_hi
);

   localparam int NT = wvl_pkg::TAPS;
   localparam int HD = NT - 1;
   localparam int LW = (NF > 1) ? $clog2(NF) : 1;

   if (NF < 1 || NF > 6) begin : g_bad_nf
      $error("wvl_fold: folded level count out of range");
   end

   logic [NF-1:0]       lane_pend;
   logic [NF-1:0]       grant;
   logic [LW-1:0]       gidx;
   logic signed [W-1:0] lane_win [NF][NT];
   logic signed [W-1:0] sel_win  [NT];
   logic signed [W-1:0] lo_y;
   logic signed [W-1:0] hi_y;

   // Lowest level has priority on the shared filter pair
   always_comb begin
      grant = '0;
      gidx  = '0;
      for (int k = NF-1; k >= 0; k--) begin
         if (lane_pend[k]) begin
            grant    = '0;
            grant[k] = 1'b1;
            gidx     = LW'(k);
         end
      end
   end

   always_comb begin
      sel_win = lane_win[0];
      for (int k = 0; k < NF; k++) begin
         if (grant[k]) sel_win = lane_win[k];
      end
   end

   wvl_dot4 #(.W(W), .FRAC(wvl_pkg::COEF_FRAC), .HIGH(1'b0)) u_lo (.win(sel_win), .y(lo_y));
   wvl_dot4 #(.W(W), .FRAC(wvl_pkg::COEF_FRAC), .HIGH(1'b1)) u_hi (.win(sel_win), .y(hi_y));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_lane  <= '0;
         res_lo    <= '0;
         res_hi    <= '0;
      end else begin
         res_valid <= |grant;
         if (|grant) begin
            res_lane <= gidx;
            res_lo   <= lo_y;
            res_hi   <= hi_y;
         end
      end
   end

   for (genvar k = 0; k < NF; k++) begin : g_lane
      logic                push;
      logic signed [W-1:0] px;
      logic signed [W-1:0] hist [HD];
      logic signed [W-1:0] win  [NT];
      logic                odd;
      logic                pend;

      if (k == 0) begin : g_src_in
         assign push = push_valid;
         assign px   = push_x;
      end else begin : g_src_fb
         assign push = res_valid && (res_lane == LW'(k-1));
         assign px   = res_lo;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < HD; i++) hist[i] <= '0;
            for (int i = 0; i < NT; i++) win[i] <= '0;
            odd  <= 1'b0;
            pend <= 1'b0;
         end else begin
            if (push) begin
               hist[0] <= px;
               for (int i = 1; i < HD; i++) hist[i] <= hist[i-1];
               odd <= ~odd;
               if (odd) begin
                  win[0] <= px;
                  for (int i = 1; i < NT; i++) win[i] <= hist[i-1];
               end
            end
            if (push && odd) begin
               pend <= 1'b1;
            end else if (grant[k]) begin
               pend <= 1'b0;
            end
         end
      end

      assign lane_pend[k] = pend;
      assign lane_win[k]  = win;

      // R8: a pending pair is served before the same level completes another
      p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (push && odd) |-> !pend);
   end

   // R8: the shared filter pair serves one level per cycle
   p_single_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R6: every folded result belongs to an existing level
   p_lane_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (int'(res_lane) < NF));

endmodule

// File: rtl/wavelet3_fold_bank.sv
module wavelet3_fold_bank #(
   parameter int W      = 12,
   parameter int LEVELS = 3,
   parameter int TAG_W  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic signed [W-1:0] in_x,
   output logic                l1_valid,
   output logic signed [W-1:0] l1_detail,
   output logic                fd_valid,
   output logic [TAG_W-1:0]    fd_level,
   output logic signed [W-1:0] fd_detail,
   output logic                apx_valid,
   output logic signed [W-1:0] apx_data
);

   localparam int NF = LEVELS - 1;
   localparam int LW = (NF > 1) ? $clog2(NF) : 1;

   if (LEVELS < 2) begin : g_bad_levels
      $error("wavelet3_fold_bank: at least two levels are needed");
   end
   if (TAG_W < $clog2(LEVELS + 1)) begin : g_bad_tag
      $error("wavelet3_fold_bank: level tag too narrow");
   end

   logic                s1_valid;
   logic signed [W-1:0] s1_lo;
   logic signed [W-1:0] s1_hi;
   logic                f_valid;
   logic [LW-1:0]       f_lane;
   logic signed [W-1:0] f_lo;
   logic signed [W-1:0] f_hi;

   wvl_stage1 #(.W(W)) u_stage1 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_x      (in_x),
      .out_valid (s1_valid),
      .out_lo    (s1_lo),
      .out_hi    (s1_hi)
   );

   wvl_fold #(.W(W), .NF(NF)) u_fold (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (s1_valid),
      .push_x     (s1_lo),
      .res_valid  (f_valid),
      .res_lane   (f_lane),
      .res_lo     (f_lo),
      .res_hi     (f_hi)
   );

   assign l1_valid  = s1_valid;
   assign l1_detail = s1_hi;
   assign fd_valid  = f_valid;
   assign fd_level  = TAG_W'(f_lane) + TAG_W'(2);
   assign fd_detail = f_hi;
   assign apx_valid = f_valid && (f_lane == LW'(NF-1));
   assign apx_data  = f_lo;

   // R7: a level-2 result trails the level-1 output that completed its pair by two cycles
   p_l2_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fd_valid && fd_level == TAG_W'(2)) |-> $past(l1_valid, 2));

   // R1: nothing is reported in the first cycle out of reset
   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!l1_valid && !fd_valid && !apx_valid));

endmodule

// File: tb/wavelet3_fold_bank_tb_top.sv
module wavelet3_fold_bank_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 100000;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               in_valid;
   logic signed [11:0] in_x;
   logic               l1_valid;
   logic signed [11:0] l1_detail;
   logic               fd_valid;
   logic [1:0]         fd_level;
   logic signed [11:0] fd_detail;
   logic               apx_valid;
   logic signed [11:0] apx_data;

   always #(CLK_PERIOD/2) clk = ~clk;

   wavelet3_fold_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_x      (in_x),
      .l1_valid  (l1_valid),
      .l1_detail (l1_detail),
      .fd_valid  (fd_valid),
      .fd_level  (fd_level),
      .fd_detail (fd_detail),
      .apx_valid (apx_valid),
      .apx_data  (apx_data)
   );

   int    n_tests = 0;
   int    n_fail  = 0;
   int    cyc     = 0;
   int    exp_d1_cyc = -1;
   bit    done    = 1'b0;
   string phase_tag = "R1 reset";

   int LO_W [4] = '{989, 1713, 459, -265};
   int HI_W [4] = '{-265, -459, 1713, -989};

   int mh  [3][3];
   bit mph [3];

   int q_d1 [$];
   int q_fd [$];
   int q_fl [$];
   int q_ap [$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s [%s]: actual %0d expected %0d", req, phase_tag, act, exp);
      end
   endtask

   // R3 rounding and R4 saturation of a weighted sum
   function automatic int rsat(input longint acc);
      longint r;
      r = (acc + 1024) >>> 11;
      if (r > 2047) r = 2047;
      if (r < -2048) r = -2048;
      return int'(r);
   endfunction

   // Bit-accurate reference of the three-level cascade
   task automatic model_push(input int x);
      int cur;
      cur = x;
      for (int l = 0; l < 3; l++) begin
         int     w [4];
         longint alo;
         longint ahi;
         int     lo;
         int     hi;
         w[0] = cur; w[1] = mh[l][0]; w[2] = mh[l][1]; w[3] = mh[l][2];
         mh[l][2] = mh[l][1];
         mh[l][1] = mh[l][0];
         mh[l][0] = cur;
         if (!mph[l]) begin
            mph[l] = 1'b1;
            break;
         end
         mph[l] = 1'b0;
         alo = 0;
         ahi = 0;
         for (int i = 0; i < 4; i++) begin
            alo += longint'(w[i]) * LO_W[i];
            ahi += longint'(w[i]) * HI_W[i];
         end
         lo = rsat(alo);
         hi = rsat(ahi);
         if (l == 0) begin
            q_d1.push_back(hi);
            exp_d1_cyc = cyc + 1;
         end else begin
            q_fd.push_back(hi);
            q_fl.push_back(l + 1);
         end
         if (l == 2) q_ap.push_back(lo);
         cur = lo;
      end
   endtask

   task automatic drive(input bit v, input int x);
      @(posedge clk);
      #1;
      in_valid = v;
      in_x     = 12'(x);
      if (v) model_push(x);
   endtask

   // Monitor: compares each produced result with the scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (cyc == exp_d1_cyc) begin
            chk(l1_valid == 1'b1, "R7 level-1 latency", int'(l1_valid), 1);
         end
         if (l1_valid) begin
            if (q_d1.size() == 0) begin
               chk(1'b0, "R2 unexpected level-1 detail", int'(l1_detail), 0);
            end else begin
               int e;
               e = q_d1.pop_front();
               chk(int'(l1_detail) == e, "R2 level-1 detail", int'(l1_detail), e);
            end
         end
         if (fd_valid) begin
            if (q_fd.size() == 0) begin
               chk(1'b0, "R6 unexpected folded detail", int'(fd_detail), 0);
            end else begin
               int e;
               int el;
               e  = q_fd.pop_front();
               el = q_fl.pop_front();
               chk(int'(fd_level) == el, "R6 folded level tag", int'(fd_level), el);
               chk(int'(fd_detail) == e, "R6 folded detail", int'(fd_detail), e);
            end
         end
         if (apx_valid) begin
            chk(fd_valid && fd_level == 2'd3, "R6 approximation with level-3 detail",
                int'(fd_level), 3);
            if (q_ap.size() == 0) begin
               chk(1'b0, "R6 unexpected approximation", int'(apx_data), 0);
            end else begin
               int e;
               e = q_ap.pop_front();
               chk(int'(apx_data) == e, "R6 approximation", int'(apx_data), e);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * WD_CYCLES);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int l = 0; l < 3; l++) begin
         mph[l] = 1'b0;
         for (int i = 0; i < 3; i++) mh[l][i] = 0;
      end
      rst_n    = 1'b0;
      in_valid = 1'b0;
      in_x     = '0;
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1: outputs quiet after reset
      @(negedge clk);
      chk(!l1_valid, "R1 l1_valid after reset", int'(l1_valid), 0);
      chk(!fd_valid, "R1 fd_valid after reset", int'(fd_valid), 0);
      chk(!apx_valid, "R1 apx_valid after reset", int'(apx_valid), 0);

      // R2: impulse response against zero history
      phase_tag = "R2 impulse";
      drive(1'b1, 1024);
      for (int i = 0; i < 15; i++) drive(1'b1, 0);

      // R3: ramp, exercising rounding on every level
      phase_tag = "R3 ramp";
      for (int i = 0; i < 32; i++) drive(1'b1, i * 61 - 900);

      // R5: gaps carrying extreme values that must be ignored
      phase_tag = "R5 gaps";
      for (int i = 0; i < 48; i++) begin
         drive(1'b1, (i * 37) % 700 - 350);
         drive(1'b0, (i % 2 == 0) ? 2047 : -2048);
         if (i % 5 == 0) drive(1'b0, 1999);
      end

      // R8: random input with random gaps stresses the interleaving
      phase_tag = "R8 random";
      for (int i = 0; i < 300; i++) begin
         int r;
         r = $urandom_range(4095);
         drive(($urandom_range(3) != 0), r - 2048);
      end

      // R4: saturation of the lowpass cascade and of the highpass
      phase_tag = "R4 saturation high";
      for (int i = 0; i < 32; i++) drive(1'b1, 2047);
      phase_tag = "R4 saturation low";
      for (int i = 0; i < 32; i++) drive(1'b1, -2048);
      phase_tag = "R4 saturation alternating";
      for (int i = 0; i < 32; i++) drive(1'b1, (i % 2 == 0) ? 2047 : -2047);

      // Drain and confirm every expected result was delivered
      phase_tag = "R6 drain";
      for (int i = 0; i < 24; i++) drive(1'b0, 0);
      @(negedge clk);
      chk(q_d1.size() == 0, "R2 level-1 results outstanding", q_d1.size(), 0);
      chk(q_fd.size() == 0, "R6 folded results outstanding", q_fd.size(), 0);
      chk(q_ap.size() == 0, "R6 approximations outstanding", q_ap.size(), 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule